// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Responder (x8)

This block is the device side of a three-wire serial EEPROM organised as bytes. It is meant to stand opposite a serial master in a test system. The master drives chip select, serial clock and data in. The block samples these pins with its own system clock. On each serial-clock rising edge while selected, it decodes a frame made of a start bit, a two-bit opcode and an address sent high bit first. It supports three commands: a write-enable, a byte write and a byte read.

The storage array is kept in block-RAM-style registers. Writes are held back by an enable latch that only reset clears. A write only commits when chip select falls after all eight data bits have arrived. The commit starts an internal write time measured in system clocks. During that time, re-selecting the device makes data out report busy as low. It reports ready as high once the write time has elapsed. Start bits that arrive during that time are ignored until the next deselect.

Top module: `mw_eeprom_responder`

## Requirements
- R1: After reset, data out and its output enable are both low and the write-enable latch is clear; the array contents are not cleared by reset.
- R2: While chip select is low, data out and its enable are low. A command that is incomplete when chip select falls is discarded without effect.
- R3: Any number of zero bits clocked in before the frame are ignored. The start bit is the first serial-clock rising edge that sees data in high while chip select is high.
- R4: The start bit is followed by two opcode bits and then ADDR_W address bits, each field sent high bit first. Opcode 10 is read and opcode 01 is write. Opcode 00 with the two top address bits at 11 sets the write-enable latch; opcode 00 with any other address value has no effect.
- R5: On a read, the rising edge that carries the last address bit drives a leading 0 on data out. The next eight rising edges each drive one data bit, bit 7 first. The ninth rising edge returns data out high.
- R6: On a write, eight data bits follow the address, bit 7 first. The byte is stored at the falling edge of chip select, and only if all eight bits were received.
- R7: A write is ignored unless the write-enable latch has been set since the last reset; the latch stays set until reset.
- R8: A committed write keeps the device busy for WRITE_CYCLES system clocks. While chip select is high in the idle or finished phase, data out is low when busy and high when ready.
- R9: A start bit received while busy is ignored together with the rest of that selection.
- R10: If chip select rises after being low for fewer than CS_LOW_MIN system clocks, that selection is ignored.
- R11: Data out and its enable are registered. They change on the second rising system-clock edge after a pin change has been set up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock from the master |
| di | input | 1 | Serial data from the master |
| dout | output | 1 | Serial data and ready/busy status to the master |
| dout_oe | output | 1 | High while data out is driven |

## Verification
Every pin is registered once and then acted on at the next system-clock edge. So each response to a serial-clock rise or to a chip-select change shows up at data out two system clocks after the pin moved. The bench reference model consumes the pins at each rising edge. It holds its prediction for one further edge before comparing at the falling edge, so the comparison lines up with that two-cycle latency.

Serial-clock half periods are three system clocks. The master-side read task therefore samples data out at the serial-clock fall, after the driven bit has settled. The busy window of WRITE_CYCLES clocks is followed clock by clock by the model's own countdown.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    ST_HUNT = 3'd0,
    ST_OPC  = 3'd1,
    ST_ADDR = 3'd2,
    ST_WDAT = 3'd3,
    ST_RDAT = 3'd4,
    ST_HOLD = 3'd5
  } mw_state_e;

  localparam logic [1:0] OPC_CTRL  = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;

endpackage

// File: rtl/mw_pin_sampler.sv
module mw_pin_sampler (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sck,
  input  logic di,
  output logic cs_q,
  output logic di_q,
  output logic sck_rise,
  output logic cs_rise,
  output logic cs_fall
);
  logic cs_d, sck_q, sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q  <= 1'b0;
      cs_d  <= 1'b0;
      sck_q <= 1'b0;
      sck_d <= 1'b0;
      di_q  <= 1'b0;
    end else begin
      cs_q  <= cs;
      cs_d  <= cs_q;
      sck_q <= sck;
      sck_d <= sck_q;
      di_q  <= di;
    end
  end

  assign sck_rise = sck_q & ~sck_d;
  assign cs_rise  = cs_q & ~cs_d;
  assign cs_fall  = ~cs_q & cs_d;
endmodule

// File: rtl/mw_busy_timer.sv
module mw_busy_timer #(
  parameter int WRITE_CYCLES = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)                remain <= '0;
    else if (start)         remain <= CNT_W'(WRITE_CYCLES);
    else if (remain != '0)  remain <= remain - CNT_W'(1);
  end

  assign busy = (remain != '0);

  // R8: the write time counts down one per clock
  p_count_down_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && !start) |=> remain == $past(remain) - CNT_W'(1));

  // R9: no new write can be launched while one is in progress
  p_no_restart_r9: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
endmodule

// File: rtl/mw_byte_array.sv
module mw_byte_array #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    if (re) rdata <= cells[raddr];
  end
endmodule

// File: rtl/mw_cmd_fsm.sv
module mw_cmd_fsm
  import mw_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 8,
  parameter int CS_LOW_MIN = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_q,
  input  logic              di_q,
  input  logic              sck_rise,
  input  logic              cs_rise,
  input  logic              cs_fall,
  input  logic              busy,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_launch,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              dout,
  output logic              dout_oe
);
  localparam int FIELD_MAX = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int CNT_W     = $clog2(FIELD_MAX + 1);
  localparam int LOW_W     = $clog2(CS_LOW_MIN + 1);

  mw_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        opc;
  logic [ADDR_W-1:0] addr_sr;
  logic [DATA_W-1:0] wdat_sr;
  logic [DATA_W-1:0] rd_sh;
  logic [LOW_W-1:0]  low_cnt;
  logic              wen;
  logic              wr_pend;
  logic [ADDR_W-1:0] full_addr;
  logic              addr_last;
  logic              locked_sel;

  assign full_addr  = {addr_sr[ADDR_W-2:0], di_q};
  assign addr_last  = (state == ST_ADDR) && (cnt == CNT_W'(ADDR_W - 1));
  assign locked_sel = cs_rise && (low_cnt < LOW_W'(CS_LOW_MIN));

  assign rd_en     = cs_q && sck_rise && addr_last && (opc == OPC_READ);
  assign rd_addr   = full_addr;
  assign wr_launch = cs_fall && wr_pend;
  assign wr_data   = wdat_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_HUNT;
      cnt     <= '0;
      opc     <= '0;
      addr_sr <= '0;
      wdat_sr <= '0;
      rd_sh   <= '0;
      wr_addr <= '0;
      low_cnt <= LOW_W'(CS_LOW_MIN);
      wen     <= 1'b0;
      wr_pend <= 1'b0;
      dout    <= 1'b0;
      dout_oe <= 1'b0;
    end else if (!cs_q) begin
      state   <= ST_HUNT;
      cnt     <= '0;
      wr_pend <= 1'b0;
      dout    <= 1'b0;
      dout_oe <= 1'b0;
      if (low_cnt < LOW_W'(CS_LOW_MIN)) low_cnt <= low_cnt + LOW_W'(1);
    end else begin
      dout_oe <= 1'b1;
      low_cnt <= '0;
      if (state != ST_RDAT) dout <= ~busy;
      if (locked_sel) begin
        state <= ST_HOLD;
      end else if (sck_rise) begin
        case (state)
          ST_HUNT: begin
            if (di_q) begin
              state <= busy ? ST_HOLD : ST_OPC;
              cnt   <= '0;
            end
          end
          ST_OPC: begin
            opc <= {opc[0], di_q};
            if (cnt == CNT_W'(1)) begin
              state <= ST_ADDR;
              cnt   <= '0;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          ST_ADDR: begin
            addr_sr <= full_addr;
            if (addr_last) begin
              cnt <= '0;
              case (opc)
                OPC_READ: begin
                  state <= ST_RDAT;
                  dout  <= 1'b0;
                end
                OPC_WRITE: begin
                  state   <= ST_WDAT;
                  wr_addr <= full_addr;
                end
                OPC_CTRL: begin
                  if (full_addr[ADDR_W-1 -: 2] == 2'b11) wen <= 1'b1;
                  state <= ST_HOLD;
                end
                default: state <= ST_HOLD;
              endcase
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          ST_WDAT: begin
            wdat_sr <= {wdat_sr[DATA_W-2:0], di_q};
            if (cnt == CNT_W'(DATA_W - 1)) begin
              state   <= ST_HOLD;
              wr_pend <= wen;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          ST_RDAT: begin
            if (cnt == CNT_W'(DATA_W)) begin
              dout  <= 1'b1;
              state <= ST_HOLD;
            end else begin
              if (cnt == '0) begin
                dout  <= rd_data[DATA_W-1];
                rd_sh <= {rd_data[DATA_W-2:0], 1'b0};
              end else begin
                dout  <= rd_sh[DATA_W-1];
                rd_sh <= {rd_sh[DATA_W-2:0], 1'b0};
              end
              cnt <= cnt + CNT_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: deselect returns to hunting and releases data out
  p_abort_r2: assert property (@(posedge clk) disable iff (rst)
    !cs_q |=> (state == ST_HUNT && !dout_oe));

  // R9: a start bit seen while busy never opens a command
  p_busy_start_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && cs_q && !cs_rise && sck_rise && state == ST_HUNT) |=> state != ST_OPC);

  // R7: enable latch only clears at reset
  p_wen_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    wen |=> wen);

  // R7: a commit is only issued with the latch set
  p_commit_gated_r7: assert property (@(posedge clk) disable iff (rst)
    wr_launch |-> wen);

  // R5: the read phase never runs past its last bit
  p_read_bits_r5: assert property (@(posedge clk) disable iff (rst)
    state == ST_RDAT |-> cnt <= CNT_W'(DATA_W));
endmodule

// File: rtl/mw_eeprom_responder.sv
module mw_eeprom_responder #(
  parameter int ADDR_W       = 9,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 400,
  parameter int CS_LOW_MIN   = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sck,
  input  logic di,
  output logic dout,
  output logic dout_oe
);
  logic              cs_q, di_q, sck_rise, cs_rise, cs_fall;
  logic              busy, rd_en, wr_launch;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;

  mw_pin_sampler u_pins (
    .clk      (clk),
    .rst      (rst),
    .cs       (cs),
    .sck      (sck),
    .di       (di),
    .cs_q     (cs_q),
    .di_q     (di_q),
    .sck_rise (sck_rise),
    .cs_rise  (cs_rise),
    .cs_fall  (cs_fall)
  );

  mw_cmd_fsm #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .CS_LOW_MIN (CS_LOW_MIN)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cs_q      (cs_q),
    .di_q      (di_q),
    .sck_rise  (sck_rise),
    .cs_rise   (cs_rise),
    .cs_fall   (cs_fall),
    .busy      (busy),
    .rd_data   (rd_data),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .wr_launch (wr_launch),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .dout      (dout),
    .dout_oe   (dout_oe)
  );

  mw_byte_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_array (
    .clk   (clk),
    .we    (wr_launch),
    .waddr (wr_addr),
    .wdata (wr_data),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  mw_busy_timer #(
    .WRITE_CYCLES (WRITE_CYCLES)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (wr_launch),
    .busy  (busy)
  );

  // R11: data out is only driven while the sampled select is high
  p_oe_follows_r11: assert property (@(posedge clk) disable iff (rst)
    dout_oe |-> $past(cs_q));
endmodule

// File: tb/sim_mw_eeprom_responder.sv
module sim_mw_eeprom_responder;
  localparam int AW  = 9;
  localparam int WC  = 400;
  localparam int LOW = 25;
  localparam int H   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, sck = 1'b0, di = 1'b0;
  logic dout, dout_oe;

  int vectors = 0, fails = 0;
  bit cmp_on = 1'b0;
  bit finished = 1'b0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  mw_eeprom_responder u0 (
    .clk(clk), .rst(rst), .cs(cs), .sck(sck), .di(di),
    .dout(dout), .dout_oe(dout_oe)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] mmem [0:511];
  int  m_st = 0, m_cnt = 0, m_lowc = LOW, m_bcnt = 0;
  int  m_op = 0, m_addr = 0, m_waddr = 0;
  logic [7:0] m_wbyte = 8'h00, m_rbyte = 8'h00;
  bit  m_wen = 0, m_wpend = 0, pv_cs = 0, pv_sck = 0;
  bit  pend_dout = 0, pend_oe = 0, exp_dout = 0, exp_oe = 0;

  initial for (int i = 0; i < 512; i++) mmem[i] = 8'h00;

  always @(posedge clk) begin
    bit busy_now, launch, rise;
    int a;
    exp_dout = pend_dout;
    exp_oe   = pend_oe;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_lowc = LOW; m_bcnt = 0; m_wen = 0; m_wpend = 0;
      pend_dout = 0; pend_oe = 0; pv_cs = 0; pv_sck = 0;
    end else begin
      busy_now = (m_bcnt != 0);
      launch = 0;
      if (!cs) begin
        if (pv_cs && m_wpend) begin mmem[m_waddr] = m_wbyte; launch = 1; end
        m_st = 0; m_cnt = 0; m_wpend = 0; pend_dout = 0; pend_oe = 0;
        if (m_lowc < LOW) m_lowc++;
      end else begin
        pend_oe = 1;
        if (m_st != 4) pend_dout = !busy_now;
        rise = sck && !pv_sck;
        if (!pv_cs && m_lowc < LOW) m_st = 5;
        else if (rise) begin
          case (m_st)
            0: if (di) begin m_st = busy_now ? 5 : 1; m_cnt = 0; m_op = 0; m_addr = 0; end
            1: begin m_op = m_op * 2 + int'(di); m_cnt++; if (m_cnt == 2) begin m_st = 2; m_cnt = 0; end end
            2: begin
              m_addr = m_addr * 2 + int'(di); m_cnt++;
              if (m_cnt == AW) begin
                a = m_addr % 512; m_cnt = 0;
                if (m_op == 2) begin m_st = 4; m_rbyte = mmem[a]; pend_dout = 0; end
                else if (m_op == 1) begin m_st = 3; m_waddr = a; end
                else begin
                  if (m_op == 0 && (a / 128) == 3) m_wen = 1;
                  m_st = 5;
                end
              end
            end
            3: begin m_wbyte = {m_wbyte[6:0], di}; m_cnt++; if (m_cnt == 8) begin m_st = 5; m_wpend = m_wen; end end
            4: begin
              if (m_cnt == 8) begin pend_dout = 1; m_st = 5; end
              else begin pend_dout = m_rbyte[7 - m_cnt]; m_cnt++; end
            end
            default: ;
          endcase
        end
        m_lowc = 0;
      end
      if (launch) m_bcnt = WC; else if (m_bcnt > 0) m_bcnt--;
    end
    pv_cs = cs; pv_sck = sck;
  end

  // ---------------- per-clock comparison ----------------
  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      vectors++;
      if (dout !== exp_dout || dout_oe !== exp_oe) begin
        fails++;
        $display("FAIL %s R11 per-clock: dout/oe actual %b%b expected %b%b at %0t",
                 cur_req, dout, dout_oe, exp_dout, exp_oe, $time);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input bit b);
    di = b; tick(H); sck = 1'b1; tick(H); sck = 1'b0;
  endtask

  task automatic sel();
    cs = 1'b1; tick(2);
  endtask

  task automatic desel(input int n);
    sck = 1'b0; di = 1'b0; cs = 1'b0; tick(n);
  endtask

  task automatic send_cmd(input int zeros, input bit [1:0] op, input bit [8:0] a);
    for (int i = 0; i < zeros; i++) sbit(1'b0);
    sbit(1'b1);
    sbit(op[1]); sbit(op[0]);
    for (int i = AW - 1; i >= 0; i--) sbit(a[i]);
  endtask

  task automatic do_write(input bit [8:0] a, input bit [7:0] d, input int nbits);
    sel();
    send_cmd(0, 2'b01, a);
    for (int i = 7; i > 7 - nbits; i--) sbit(d[i]);
    desel(LOW + 2);
  endtask

  task automatic do_read(input bit [8:0] a, input int zeros, output bit [7:0] v);
    sel();
    send_cmd(zeros, 2'b10, a);
    chk(dout == 1'b0, "R5 leading zero", dout, 0);
    v = '0;
    for (int i = 0; i < 8; i++) begin
      sbit(1'b0);
      v = {v[6:0], dout};
    end
    sbit(1'b0);
    chk(dout == 1'b1, "R5 high after last bit", dout, 1);
    desel(LOW + 2);
  endtask

  task automatic poll_ready(input string req);
    int n = 0;
    sel();
    while (dout !== 1'b1 && n < 5000) begin tick(1); n++; end
    chk(dout == 1'b1, req, dout, 1);
    desel(LOW + 2);
  endtask

  task automatic ewen();
    sel(); send_cmd(0, 2'b00, 9'h180); desel(LOW + 2);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    bit [7:0] rv;
    tick(3);
    cmp_on = 1'b1;
    tick(2);
    rst = 1'b0;
    tick(2);
    cur_req = "R1";
    chk(dout == 1'b0 && dout_oe == 1'b0, "R1 reset outputs", {dout, dout_oe}, 0);

    cur_req = "R4";
    ewen();
    cur_req = "R6";
    do_write(9'h010, 8'h5A, 8);
    sel();
    chk(dout == 1'b0 && dout_oe == 1'b1, "R8 busy low after write", {dout, dout_oe}, 1);
    desel(LOW + 2);
    poll_ready("R8 ready after write time");

    cur_req = "R9";
    do_write(9'h1FF, 8'hC3, 8);
    do_write(9'h010, 8'hEE, 8);
    poll_ready("R9 ready");
    do_read(9'h010, 0, rv);
    chk(rv == 8'h5A, "R9 write while busy ignored", rv, 8'h5A);

    cur_req = "R3";
    do_read(9'h1FF, 5, rv);
    chk(rv == 8'hC3, "R3 leading zeros before start", rv, 8'hC3);

    cur_req = "R2";
    do_write(9'h010, 8'h77, 5);
    sel();
    chk(dout == 1'b1, "R2 aborted write not busy", dout, 1);
    desel(LOW + 2);
    do_read(9'h010, 0, rv);
    chk(rv == 8'h5A, "R2 aborted write no effect", rv, 8'h5A);

    cur_req = "R7";
    rst = 1'b1; tick(3); rst = 1'b0; tick(2);
    chk(dout == 1'b0 && dout_oe == 1'b0, "R1 outputs after second reset", {dout, dout_oe}, 0);
    do_write(9'h010, 8'h99, 8);
    sel();
    chk(dout == 1'b1, "R7 disabled write not busy", dout, 1);
    desel(LOW + 2);
    do_read(9'h010, 0, rv);
    chk(rv == 8'h5A, "R7 write before enable ignored", rv, 8'h5A);

    cur_req = "R4";
    sel(); send_cmd(0, 2'b00, 9'h000); desel(LOW + 2);
    do_write(9'h010, 8'h99, 8);
    do_read(9'h010, 0, rv);
    chk(rv == 8'h5A, "R4 non-enable control has no effect", rv, 8'h5A);

    cur_req = "R10";
    ewen();
    sel();
    desel(2);
    sel();
    send_cmd(0, 2'b01, 9'h010);
    for (int i = 7; i >= 0; i--) sbit(1'b0);
    desel(LOW + 2);
    sel();
    chk(dout == 1'b1, "R10 short deselect write not busy", dout, 1);
    desel(LOW + 2);
    do_read(9'h010, 0, rv);
    chk(rv == 8'h5A, "R10 short deselect ignored", rv, 8'h5A);

    cur_req = "R6";
    do_write(9'h010, 8'h33, 8);
    poll_ready("R8 ready after second write");
    do_read(9'h010, 0, rv);
    chk(rv == 8'h33, "R6 byte written", rv, 8'h33);
    do_read(9'h1FF, 2, rv);
    chk(rv == 8'hC3, "R5 top address readback", rv, 8'hC3);

    tick(4);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule